// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is a 32-line general-purpose I/O port. A small register bus lets software set each line as an input or an output. An output can be push-pull or open-drain. Software also sets the output value and reads back a data view. In that view, output lines show their stored value and input lines show their synchronised pad level. An input buffer enable decides, line by line, whether an input pad value reaches that view.

Every pad passes through a two-flop synchroniser. The block then watches the synchronised levels for edges. A per-line sense bit picks between two detection modes: any change, or falling edges only. A detected edge latches a bit in an event register, and that bit stays set until software writes a one to it. A mask register selects which latched events drive the single interrupt output. Line n sits at register bit 31−n, so line 0 is the most significant bit.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and no `pad_oe` bit is set.
- R2: The direction (0x00), open-drain (0x04), data (0x08), mask (0x10), sense (0x14) and input-enable (0x18) registers read back the last value written. Writes take effect on the clock edge that samples `bus_we`.
- R3: Line n of `pad_in`, `pad_out` and `pad_oe` corresponds to register bit 31−n.
- R4: A line whose direction bit is 1 is an output. With its open-drain bit 0, it drives `pad_oe`=1 and `pad_out`=data bit. A line whose direction bit is 0 never drives `pad_oe`.
- R5: An output line whose open-drain bit is 1 drives `pad_oe`=1 with `pad_out`=0 when its data bit is 0. It drives `pad_oe`=0 when its data bit is 1.
- R6: A read of offset 0x08 returns the stored data bit for output lines. For input lines it returns the synchronised pad value when the input-enable bit is 1, and 0 otherwise. A pad change is visible after the second rising clock edge.
- R7: With a sense bit of 0, both rising and falling pad transitions set the event bit (offset 0x0C) on the third rising edge after the pad change.
- R8: With a sense bit of 1, only falling transitions set the event bit. Rising transitions leave it clear.
- R9: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. An event bit is cleared by nothing else.
- R10: When an edge sets an event bit in the same cycle as a write that clears it, the bit ends up set.
- R11: `irq` is high exactly when some bit is set in both the event and the mask registers.
- R12: Reads of offset 0x1C, or of any address whose two low bits are not zero, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input levels, indexed by line |
| pad_out | output | 32 | Pad output values, indexed by line |
| pad_oe | output | 32 | Pad output enables, indexed by line |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench drives a write that clears an event bit on the very edge where a new edge lands on that bit. A design that let the clear win would lose that event silently. Rising pads are applied under falling-only sense; a decoder that ignored the sense bit would latch them. The bench probes each line at its mirrored bit position, so any design that numbered lines straight would show the wrong pins driving. It also samples the data view and the event register one cycle before each is due, which catches a synchroniser that is a stage short or long. Open-drain lines holding a data one must float, so a design that drove them high would show up at `pad_oe`.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIR   = 3'd0,
    SEL_OD    = 3'd1,
    SEL_DATA  = 3'd2,
    SEL_EVT   = 3'd3,
    SEL_MASK  = 3'd4,
    SEL_SENSE = 3'd5,
    SEL_IBE   = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  // Word-aligned decode; misaligned addresses select nothing.
  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00) return SEL_NONE;
    return reg_sel_e'(a[ADDR_W-1:2]);
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] fall_only,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] evt
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] evt_q, evt_d;

  // Per-bit edge qualification: falling edges always count, rising ones
  // only when the sense bit is 0.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      hit[b] = 1'b0;
      if (prev_q[b] && !level[b])       hit[b] = 1'b1;
      else if (!prev_q[b] && level[b])  hit[b] = !fall_only[b];
    end
  end

  // Set wins over a simultaneous write-one clear.
  always_comb begin
    evt_d = (evt_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= level;
      evt_q  <= evt_d;
    end
  end

  assign evt = evt_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_edge_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir,
  output logic [WIDTH-1:0] od,
  output logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] sense,
  output logic [WIDTH-1:0] ibe
);
  logic en_dir, en_od, en_data, en_mask, en_sense, en_ibe;
  logic [WIDTH-1:0] dir_q, od_q, data_q, mask_q, sense_q, ibe_q;
  logic [WIDTH-1:0] dir_d, od_d, data_d, mask_d, sense_d, ibe_d;

  always_comb begin
    en_dir   = we && (sel == SEL_DIR);
    en_od    = we && (sel == SEL_OD);
    en_data  = we && (sel == SEL_DATA);
    en_mask  = we && (sel == SEL_MASK);
    en_sense = we && (sel == SEL_SENSE);
    en_ibe   = we && (sel == SEL_IBE);
    dir_d    = wdata;
    od_d     = wdata;
    data_d   = wdata;
    mask_d   = wdata;
    sense_d  = wdata;
    ibe_d    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      od_q    <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      ibe_q   <= '0;
    end else begin
      if (en_dir)   dir_q   <= dir_d;
      if (en_od)    od_q    <= od_d;
      if (en_data)  data_q  <= data_d;
      if (en_mask)  mask_q  <= mask_d;
      if (en_sense) sense_q <= sense_d;
      if (en_ibe)   ibe_q   <= ibe_d;
    end
  end

  assign dir   = dir_q;
  assign od    = od_q;
  assign data  = data_q;
  assign mask  = mask_q;
  assign sense = sense_q;
  assign ibe   = ibe_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic              irq
);
  localparam int unsigned MSB = NLINES - 1;

  logic             rst_n_i;
  reg_sel_e         sel;
  logic [MSB:0]     pad_reg, lvl;
  logic [MSB:0]     dir_q, od_q, data_q, mask_q, sense_q, ibe_q, evt_q;
  logic [MSB:0]     evt_clr, data_view, out_r, oe_r;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  assign sel = decode_addr(bus_addr);

  // Line n <-> register bit MSB-n.
  for (genvar n = 0; n < NLINES; n++) begin : g_line
    assign pad_reg[MSB-n] = pad_in[n];
    assign pad_out[n]     = out_r[MSB-n];
    assign pad_oe[n]      = oe_r[MSB-n];
  end

  gpio_sync #(.WIDTH(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d(pad_reg), .q(lvl)
  );

  gpio_regfile #(.WIDTH(NLINES)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .we(bus_we), .sel(sel), .wdata(bus_wdata),
    .dir(dir_q), .od(od_q), .data(data_q), .mask(mask_q),
    .sense(sense_q), .ibe(ibe_q)
  );

  always_comb begin
    evt_clr = (bus_we && sel == SEL_EVT) ? bus_wdata : '0;
  end

  gpio_edge_det #(.WIDTH(NLINES)) u_edge (
    .clk(clk), .rst_n(rst_n_i), .level(lvl), .fall_only(sense_q),
    .clr(evt_clr), .evt(evt_q)
  );

  always_comb begin
    data_view = (dir_q & data_q) | (~dir_q & ibe_q & lvl);
    oe_r      = dir_q & (~od_q | ~data_q);
    out_r     = ~od_q & data_q;
    irq       = |(evt_q & mask_q);
  end

  always_comb begin
    unique case (sel)
      SEL_DIR:   bus_rdata = dir_q;
      SEL_OD:    bus_rdata = od_q;
      SEL_DATA:  bus_rdata = data_view;
      SEL_EVT:   bus_rdata = evt_q;
      SEL_MASK:  bus_rdata = mask_q;
      SEL_SENSE: bus_rdata = sense_q;
      SEL_IBE:   bus_rdata = ibe_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int unsigned NLINES = 32
) (
  input logic              clk,
  input logic              rst_n_i,
  input logic [4:0]        bus_addr,
  input logic              bus_we,
  input logic [NLINES-1:0] bus_wdata,
  input logic [NLINES-1:0] evt_q,
  input logic [NLINES-1:0] mask_q,
  input logic [NLINES-1:0] sense_q,
  input logic [NLINES-1:0] lvl,
  input logic [NLINES-1:0] dir_q,
  input logic [NLINES-1:0] od_q,
  input logic [NLINES-1:0] data_q,
  input logic [NLINES-1:0] oe_r,
  input logic              irq
);
  logic [1:0]        age_q;
  logic [NLINES-1:0] clr_w;
  logic              ready;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)            age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assign ready = (age_q == 2'd3);
  assign clr_w = (bus_we && bus_addr == 5'h0C) ? bus_wdata : '0;

  // R9
  evt_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ready |-> ((($past(evt_q) & ~evt_q) & ~$past(clr_w)) == '0));

  // R7
  evt_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ready |-> (((evt_q & ~$past(evt_q)) & ~($past(lvl) ^ $past(lvl, 2))) == '0));

  // R8
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ready |-> ((evt_q & ~$past(evt_q) & $past(sense_q) & $past(lvl)) == '0));

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((mask_q == '0) || (evt_q == '0)) |-> !irq);

  // R5
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (oe_r & od_q & data_q) == '0);

  // R4
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (oe_r & ~dir_q) == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n_i(rst_n_i), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .evt_q(evt_q), .mask_q(mask_q), .sense_q(sense_q),
  .lvl(lvl), .dir_q(dir_q), .od_q(od_q), .data_q(data_q), .oe_r(oe_r),
  .irq(irq)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port i_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic settle_and_clear();
    repeat (4) @(negedge clk);
    wr(5'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    chk("R1 pad_oe reset", pad_oe, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'h00, 32'h1234_5678); rd(5'h00, v); chk("R2 dir", v, 32'h1234_5678);
    wr(5'h04, 32'hA5A5_0F0F); rd(5'h04, v); chk("R2 od", v, 32'hA5A5_0F0F);
    wr(5'h10, 32'h0F0F_F0F0); rd(5'h10, v); chk("R2 mask", v, 32'h0F0F_F0F0);
    wr(5'h14, 32'hDEAD_BEEF); rd(5'h14, v); chk("R2 sense", v, 32'hDEAD_BEEF);
    wr(5'h18, 32'h0000_FFFF); rd(5'h18, v); chk("R2 ibe", v, 32'h0000_FFFF);
    rd(5'h1C, v); chk("R12 unmapped", v, 32'h0);
    rd(5'h01, v); chk("R12 misaligned", v, 32'h0);
    wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h10, 32'h0);
    wr(5'h14, 32'h0); wr(5'h18, 32'h0);
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h00, 32'h8000_0001);
    chk("R3 R4 oe lines 0 and 31", pad_oe, 32'h8000_0001);
    chk("R4 push-pull out", pad_out & pad_oe, 32'h8000_0001);
    rd(5'h08, v);
    chk("R6 data view outputs, inputs gated off", v, 32'h8000_0001);
    wr(5'h04, 32'h8000_0000);
    chk("R5 open-drain data 1 floats line 0", pad_oe, 32'h8000_0000);
    wr(5'h08, 32'h7FFF_FFFF);
    chk("R5 open-drain data 0 drives line 0", pad_oe, 32'h8000_0001);
    chk("R5 open-drain drives low", {31'b0, pad_out[0]}, 32'h0);
    wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h08, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    wr(5'h18, 32'hFFFF_FFFE);
    set_pad(32'h8000_0001);
    @(posedge clk); @(negedge clk);
    rd(5'h08, v); chk("R6 not yet visible after one edge", v, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(5'h08, v); chk("R6 R3 visible after two edges, bit 0 gated", v, 32'h8000_0000);
    set_pad(32'h0);
    settle_and_clear();
    wr(5'h18, 32'h0);
  endtask

  task automatic t_both_edges();
    logic [31:0] v;
    set_pad(32'h0000_0020);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(5'h0C, v); chk("R7 event not before third edge", v, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(5'h0C, v); chk("R7 rising event line 5", v, 32'h0400_0000);
    wr(5'h0C, 32'h0);
    rd(5'h0C, v); chk("R9 write 0 keeps event", v, 32'h0400_0000);
    wr(5'h0C, 32'h0400_0000);
    rd(5'h0C, v); chk("R9 write 1 clears event", v, 32'h0);
    set_pad(32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(5'h0C, v); chk("R7 falling event line 5", v, 32'h0400_0000);
    wr(5'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_fall_only();
    logic [31:0] v;
    wr(5'h14, 32'h0400_0000);
    set_pad(32'h0000_0020);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(5'h0C, v); chk("R8 rising ignored", v, 32'h0);
    set_pad(32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(5'h0C, v); chk("R8 falling latched", v, 32'h0400_0000);
    wr(5'h14, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    chk("R11 unmasked event keeps irq low", {31'b0, irq}, 32'h0);
    wr(5'h10, 32'h0400_0000);
    chk("R11 masked event raises irq", {31'b0, irq}, 32'h1);
    wr(5'h0C, 32'h0400_0000);
    chk("R11 irq drops after clear", {31'b0, irq}, 32'h0);
    rd(5'h0C, v); chk("R9 event clear", v, 32'h0);
    wr(5'h10, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    set_pad(32'h8000_0000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    set_pad(32'h8000_0020);
    @(posedge clk); @(posedge clk);
    wr(5'h0C, 32'h0400_0001);
    rd(5'h0C, v); chk("R10 set beats clear, other bit cleared", v, 32'h0400_0000);
    set_pad(32'h0);
    settle_and_clear();
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_outputs();
    t_input();
    t_both_edges();
    t_fall_only();
    t_irq();
    t_set_wins();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule